// File: doc/BRIEF.md
# DAC Bring-Up Command Sequencer

This block runs on the host side of a serial link to a precision voltage DAC that takes 24-bit command frames. One pulse on `start` makes it issue a fixed series of frames through a frame-level shifter. The shifter takes one request and returns one acknowledge per frame. It also returns the 24 bits it received while that frame was shifted out.

The frames are sent in this order:
1. The configuration word, which selects offset-binary coding, normal output mode, no ground clamp, the internal amplifier powered down and the serial data output enabled.
2. A DAC-register write carrying a caller-supplied code.
3. A clearcode-register write carrying a second caller-supplied code.
4. A software-clear command.
5. A clearcode read command.
6. A no-operation frame. The shifter clocks back the readback word while this frame is shifted.

The configuration goes first because the coding selection changes how every later data code is interpreted.

When the last frame is acknowledged, the block compares the returned clearcode with the code it wrote. It compares only the data bits that are meaningful at the configured converter width. It then raises a one-cycle `done` pulse. A mismatch sets a sticky error flag, which the next accepted start clears.

Top module: `dis_init_seq`

## Requirements
- R1: A `start` pulse while not busy makes `busy` high from the next cycle. In that same cycle `err` clears and `frm_req` rises with `frm_word` = 0x200012.
- R2: The frames are issued in this order: 0x200012, the DAC write, the clearcode write, 0x400002, 0xB00000, 0x000000.
- R3: The DAC write frame is {4'b0001, code}. The code is `dac_code` with its low 20-DAC_BITS bits forced to zero.
- R4: The clearcode write frame is {4'b0011, code}. The code is `clr_code` with its low 20-DAC_BITS bits forced to zero.
- R5: While `frm_req` is high and `frm_ack` is low, `frm_req` stays high and `frm_word` does not change.
- R6: After any acknowledge, `frm_req` is low for at least one cycle. The next frame is requested in the cycle after that.
- R7: In the cycle after the sixth frame is acknowledged, `done` is high for exactly one cycle and `busy` is low.
- R8: When the sixth frame is acknowledged, `err` is set if `frm_rdata[19 -: DAC_BITS]` differs from the same bits of the `clr_code` captured at start. Bits of `frm_rdata` below bit 20-DAC_BITS have no effect.
- R9: `err` holds its value until the next accepted start. A `start` pulse while busy is ignored and does not change the frame sequence.
- R10: After reset, `busy`, `done`, `err` and `frm_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the bring-up sequence (ignored while busy) |
| dac_code | input | 20 | Code for the DAC register, MSB-aligned |
| clr_code | input | 20 | Code for the clearcode register, MSB-aligned |
| frm_req | output | 1 | Frame request to the shifter |
| frm_word | output | 24 | Frame to transmit |
| frm_ack | input | 1 | One-cycle pulse when the frame has been shifted |
| frm_rdata | input | 24 | Word received during the acknowledged frame |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence ends |
| err | output | 1 | Sticky readback-mismatch flag |

## Verification
The sequence is run four times with different combinations of acknowledge latency (zero to three cycles), codes and returned words. One run returns the correct clearcode with its unused low bits flipped, so it tells apart a compare limited to the valid bits from one over the whole field. Two runs return words that differ in the top data bit and in the lowest compared bit, which exposes an off-by-one in the compared slice. One run pulses `start` mid-sequence to show that it is ignored. The run that follows an error shows that the next start clears the flag.

// File: rtl/dis_pkg.sv
package dis_pkg;
    localparam int CODE_W    = 20;
    localparam int FRAME_W   = 24;
    localparam int NUM_FRM   = 6;
    localparam int IDX_W     = 3;

    localparam logic [FRAME_W-1:0] FRM_CFG   = 24'h200012;
    localparam logic [FRAME_W-1:0] FRM_SWCLR = 24'h400002;
    localparam logic [FRAME_W-1:0] FRM_RDCLR = 24'hB00000;
    localparam logic [FRAME_W-1:0] FRM_NOP   = 24'h000000;
    localparam logic [3:0]         HDR_DAC   = 4'b0001;
    localparam logic [3:0]         HDR_CLR   = 4'b0011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_GAP
    } seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        logic [IDX_W-1:0]    idx;
        logic                req;
        logic [FRAME_W-1:0]  word;
        logic                busy;
        logic                done;
        logic                err;
        logic [CODE_W-1:0]   dac;
        logic [CODE_W-1:0]   clr;
    } seq_t;
endpackage

// File: rtl/dis_frame_sel.sv
module dis_frame_sel
    import dis_pkg::*;
#(
    parameter int DAC_BITS = 18
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [CODE_W-1:0]  dac_code,
    input  logic [CODE_W-1:0]  clr_code,
    output logic [FRAME_W-1:0] word
);
    localparam int PAD = CODE_W - DAC_BITS;

    logic [CODE_W-1:0] keep_mask;

    generate
        if (PAD == 0) begin : g_full
            assign keep_mask = {CODE_W{1'b1}};
        end else begin : g_pad
            assign keep_mask = {{DAC_BITS{1'b1}}, {PAD{1'b0}}};
        end
    endgenerate

    always_comb begin
        case (idx)
            3'd0:    word = FRM_CFG;
            3'd1:    word = {HDR_DAC, dac_code & keep_mask};
            3'd2:    word = {HDR_CLR, clr_code & keep_mask};
            3'd3:    word = FRM_SWCLR;
            3'd4:    word = FRM_RDCLR;
            default: word = FRM_NOP;
        endcase
    end
endmodule

// File: rtl/dis_rb_cmp.sv
module dis_rb_cmp
    import dis_pkg::*;
#(
    parameter int DAC_BITS = 18
) (
    input  logic [FRAME_W-1:0] rdata,
    input  logic [CODE_W-1:0]  expect_code,
    output logic               mismatch
);
    localparam int TOP = CODE_W - 1;

    logic [DAC_BITS-1:0] got_bits;
    logic [DAC_BITS-1:0] exp_bits;

    assign got_bits = rdata[TOP -: DAC_BITS];
    assign exp_bits = expect_code[TOP -: DAC_BITS];
    assign mismatch = (got_bits != exp_bits);
endmodule

// File: rtl/dis_init_seq.sv
module dis_init_seq
    import dis_pkg::*;
#(
    parameter int DAC_BITS = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [19:0]         dac_code,
    input  logic [19:0]         clr_code,
    output logic                frm_req,
    output logic [23:0]         frm_word,
    input  logic                frm_ack,
    input  logic [23:0]         frm_rdata,
    output logic                busy,
    output logic                done,
    output logic                err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRM - 1);

    seq_t               s_q;
    seq_t               s_d;
    logic [FRAME_W-1:0] sel_word;
    logic               rb_bad;

    dis_frame_sel #(.DAC_BITS(DAC_BITS)) u_sel (
        .idx      (s_q.idx),
        .dac_code (s_q.dac),
        .clr_code (s_q.clr),
        .word     (sel_word)
    );

    dis_rb_cmp #(.DAC_BITS(DAC_BITS)) u_cmp (
        .rdata       (frm_rdata),
        .expect_code (s_q.clr),
        .mismatch    (rb_bad)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_SEND;
                    s_d.idx  = '0;
                    s_d.req  = 1'b1;
                    s_d.word = FRM_CFG;
                    s_d.busy = 1'b1;
                    s_d.err  = 1'b0;
                    s_d.dac  = dac_code;
                    s_d.clr  = clr_code;
                end
            end
            ST_SEND: begin
                if (frm_ack) begin
                    s_d.req = 1'b0;
                    if (s_q.idx == LAST_IDX) begin
                        s_d.st   = ST_IDLE;
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                        s_d.err  = rb_bad;
                    end else begin
                        s_d.st  = ST_GAP;
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                s_d.st   = ST_SEND;
                s_d.req  = 1'b1;
                s_d.word = sel_word;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, idx: '0, req: 1'b0, word: '0, busy: 1'b0,
                     done: 1'b0, err: 1'b0, dac: '0, clr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign frm_req  = s_q.req;
    assign frm_word = s_q.word;
    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign err      = s_q.err;

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !err && frm_req && frm_word == FRM_CFG));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_req && !frm_ack) |=> (frm_req && $stable(frm_word)));

    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_req && frm_ack) |=> !frm_req);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !frm_req));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(start && !busy) && !(frm_req && frm_ack && s_q.idx == LAST_IDX))
        |=> $stable(err));
endmodule

// File: tb/dis_init_seq_test.sv
module dis_init_seq_test;
    localparam int BITS = 18;
    localparam int PAD  = 20 - BITS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] dac_code = '0;
    logic [19:0] clr_code = '0;
    logic        frm_req;
    logic [23:0] frm_word;
    logic        frm_ack = 1'b0;
    logic [23:0] frm_rdata = '0;
    logic        busy, done, err;

    always #10 clk = ~clk;

    dis_init_seq #(.DAC_BITS(BITS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dac_code(dac_code), .clr_code(clr_code),
        .frm_req(frm_req), .frm_word(frm_word),
        .frm_ack(frm_ack), .frm_rdata(frm_rdata),
        .busy(busy), .done(done), .err(err)
    );

    int checks = 0;
    int fails  = 0;

    bit          m_req, m_busy, m_done, m_err;
    logic [23:0] m_word;
    int          m_idx;
    logic [19:0] m_clr;
    logic [23:0] m_q[$];
    int          lat, cnt;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [19:0] trim(input logic [19:0] c);
        return (c >> PAD) << PAD;
    endfunction

    task automatic step(input bit st_pulse);
        bit a;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 32'(m_busy));
        chk("R7 done", 32'(done), 32'(m_done));
        chk("R8/R9 err", 32'(err), 32'(m_err));
        chk("R6 req", 32'(frm_req), 32'(m_req));
        if (m_req) begin
            if (m_idx == 1)      chk("R3 dac frame", 32'(frm_word), 32'(m_word));
            else if (m_idx == 2) chk("R4 clr frame", 32'(frm_word), 32'(m_word));
            else                 chk("R2/R5 frame", 32'(frm_word), 32'(m_word));
        end
        a = frm_req && (cnt >= lat);
        if (a) cnt = 0;
        else if (frm_req) cnt++;
        frm_ack = a;
        start   = st_pulse;
        m_done  = 1'b0;
        if (!m_busy) begin
            if (st_pulse) begin
                m_q.delete();
                m_q.push_back(24'h200012);
                m_q.push_back({4'b0001, trim(dac_code)});
                m_q.push_back({4'b0011, trim(clr_code)});
                m_q.push_back(24'h400002);
                m_q.push_back(24'hB00000);
                m_q.push_back(24'h000000);
                m_clr  = clr_code;
                m_busy = 1'b1;
                m_err  = 1'b0;
                m_req  = 1'b1;
                m_idx  = 0;
                m_word = m_q.pop_front();
            end
        end else if (m_req) begin
            if (a) begin
                m_req = 1'b0;
                if (m_q.size() == 0) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                    m_err  = ((frm_rdata[19:0] >> PAD) != (m_clr >> PAD));
                end
            end
        end else begin
            m_req  = 1'b1;
            m_idx++;
            m_word = m_q.pop_front();
        end
    endtask

    task automatic run(input logic [19:0] dc, input logic [19:0] cc,
                       input logic [23:0] rb, input int l, input int extra_at);
        dac_code  = dc;
        clr_code  = cc;
        frm_rdata = rb;
        lat = l;
        cnt = 0;
        step(1'b1);
        for (int i = 0; i < 400 && (m_busy || m_done); i++) step(i == extra_at);
        step(1'b0);
    endtask

    initial begin
        m_req = 0; m_busy = 0; m_done = 0; m_err = 0; m_word = '0; m_idx = 0;
        m_clr = '0; lat = 0; cnt = 0;
        repeat (3) @(negedge clk);
        chk("R10 busy", 32'(busy), 0);
        chk("R10 done", 32'(done), 0);
        chk("R10 err", 32'(err), 0);
        chk("R10 req", 32'(frm_req), 0);
        rst_n = 1'b1;
        // R8: correct readback with unused low bits flipped, no error
        run(20'h80000, 20'hFFFFF, {4'h3, 20'hFFFFF ^ 20'h3}, 0, -1);
        // R8/R9: top data bit wrong, start pulsed mid-run
        run(20'h12345, 20'h0ABCD, {4'h3, 20'h0ABCD ^ 20'h80000}, 3, 7);
        // R9: next start clears err
        run(20'hFFFFF, 20'h5A5A5, {4'h0, 20'h5A5A5}, 1, -1);
        // R8: lowest compared bit wrong
        run(20'h00003, 20'h3C3C0, {4'h3, 20'h3C3C0 ^ (20'h1 << PAD)}, 2, -1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule